// File: doc/BRIEF.md
# Configurable Serial Transmit Shifter

This block is the output stage of a synchronous audio-style serial transmitter. It takes one 32-bit word at a time from an external transmit queue. It picks the active sample out of that word and sends it, one bit per shift opportunity, on a single data output. Three settings control which bits form the sample and in what order they leave:

- the sample length;
- whether the sample sits at the high or the low end of the word;
- whether the most or the least significant bit goes first.

Everything runs on the system clock. A single-cycle bit-clock enable strobe marks each shift opportunity. In continuous-clock mode, a strobe counts only while frame sync is high. In gated-clock mode, every strobe counts.

After the last bit of a sample has left, the block reports that it is empty and pulses a request for the next word. If no word is waiting at the next shift opportunity, the data output is driven low until a word arrives. Loading happens on a shift opportunity: the first bit of the new sample appears on the output on the same edge that loads it.

Top module: `serial_tx_shifter`

## Requirements
- R1: While reset is active and right after it is released, `txd` is 0, `tx_empty` is 1 and `load_req` is 0.
- R2: `wl_sel` codes 0 to 7 select sample lengths of 8, 10, 12, 16, 18, 20, 22 and 24 bits. Codes 8 to 15 select 24 bits. Exactly that many shift opportunities send one sample.
- R3: With `align_low`=1, the sample is bits [L-1:0] of `fifo_word`, and all higher bits are ignored.
- R4: With `align_low`=0 and a length L of 16 or more, the sample is bits [23:24-L] of `fifo_word`. Bits 31:24 and the bits below the sample are ignored.
- R5: With `align_low`=0 and a length L below 16, the sample is bits [15:16-L] of `fifo_word`.
- R6: With `lsb_first`=0 the sample goes out most significant bit first. With `lsb_first`=1 it goes out least significant bit first.
- R7: With `gated_mode`=0, a shift opportunity is a cycle where `bclk_en` and `frame_sync` are both 1. `txd` changes only on a shift opportunity.
- R8: With `gated_mode`=1, every cycle with `bclk_en`=1 is a shift opportunity, whatever the value of `frame_sync`.
- R9: On a shift opportunity while `tx_empty`=1 and `fifo_valid`=1, the word is loaded, its first bit is on `txd` after that edge, and `tx_empty` goes to 0.
- R10: After the shift opportunity that sends the last bit of a sample, `tx_empty` is 1 and `load_req` is 1 for exactly one cycle.
- R11: A shift opportunity while `tx_empty`=1 and `fifo_valid`=0 drives `txd` to 0.
- R12: `wl_sel`, `align_low`, `lsb_first` and `fifo_word` are sampled only at load. Changing them while a sample is being sent does not alter the bits of that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bclk_en | input | 1 | Single-cycle bit-clock enable strobe |
| frame_sync | input | 1 | Frame sync that qualifies shifting in continuous mode |
| gated_mode | input | 1 | 1: gated-clock mode, 0: continuous-clock mode |
| wl_sel | input | 4 | Sample length code |
| align_low | input | 1 | 1: sample at the low end of the word, 0: at the high end |
| lsb_first | input | 1 | 1: least significant bit first, 0: most significant bit first |
| fifo_word | input | 32 | Word offered by the transmit queue |
| fifo_valid | input | 1 | `fifo_word` holds a word ready to load |
| txd | output | 1 | Serial data output |
| tx_empty | output | 1 | No sample bits remain to be sent |
| load_req | output | 1 | One-cycle request for the next word |

## Verification
The assertions assume three things about the inputs:
- `bclk_en` is a strobe in the system clock domain.
- `fifo_valid`, once raised, stays up until the block leaves the empty state.
- A sample length is always at least 8, so a request can never overlap a load.

The stimulus keeps within these limits. It raises `fifo_valid` only while the block is empty, and drops it on the first falling edge after `tx_empty` falls. It changes the mode and the enable pattern only between samples. It changes the format inputs mid-sample only in the dedicated test for that case.

// File: rtl/stx_pkg.sv
package stx_pkg;

  localparam int STX_FIFO_W  = 32;
  localparam int STX_SR_W    = 24;
  localparam int STX_SPLIT_W = 16;
  localparam int STX_CODE_W  = 4;

  // Sample length for a length code; unknown codes select the full register.
  function automatic int len_of(input int code);
    case (code)
      0:       return 8;
      1:       return 10;
      2:       return 12;
      3:       return 16;
      4:       return 18;
      5:       return 20;
      6:       return 22;
      7:       return 24;
      default: return STX_SR_W;
    endcase
  endfunction

endpackage

// File: rtl/stx_rst_sync.sv
module stx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_n;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/stx_word_align.sv
module stx_word_align #(
  parameter int FIFO_W  = 32,
  parameter int SR_W    = 24,
  parameter int SPLIT_W = 16,
  parameter int LEN_W   = $clog2(SR_W + 1)
) (
  input  logic [FIFO_W-1:0] word,
  input  logic [LEN_W-1:0]  len,
  input  logic              align_low,
  output logic [SR_W-1:0]   sample
);

  logic [SR_W-1:0]  base;
  logic [SR_W-1:0]  low_half;
  logic [SR_W:0]    mask_w;
  logic [LEN_W-1:0] sh_high;
  logic [LEN_W-1:0] sh_split;
  logic             unused_upper;

  assign base         = word[SR_W-1:0];
  assign unused_upper = ^word[FIFO_W-1:SR_W];
  assign low_half     = {{(SR_W-SPLIT_W){1'b0}}, base[SPLIT_W-1:0]};

  always_comb begin
    mask_w   = ((SR_W+1)'(1) << len) - (SR_W+1)'(1);
    sh_high  = LEN_W'(SR_W) - len;
    sh_split = LEN_W'(SPLIT_W) - len;
    if (align_low) begin
      sample = base & mask_w[SR_W-1:0];
    end else if (len >= LEN_W'(SPLIT_W)) begin
      sample = (base >> sh_high) & mask_w[SR_W-1:0];
    end else begin
      sample = (low_half >> sh_split) & mask_w[SR_W-1:0];
    end
  end

endmodule

// File: rtl/stx_bit_order.sv
module stx_bit_order #(
  parameter int SR_W  = 24,
  parameter int LEN_W = $clog2(SR_W + 1)
) (
  input  logic [SR_W-1:0]  sample,
  input  logic [LEN_W-1:0] len,
  input  logic             lsb_first,
  output logic [SR_W-1:0]  image
);

  logic [SR_W-1:0] top_just;
  logic [SR_W-1:0] reversed;

  assign top_just = sample << (LEN_W'(SR_W) - len);

  for (genvar g = 0; g < SR_W; g++) begin : g_rev
    assign reversed[g] = top_just[SR_W-1-g];
  end

  // The engine always shifts toward bit 0, so bit 0 holds the first bit out.
  assign image = lsb_first ? sample : reversed;

endmodule

// File: rtl/stx_shift_engine.sv
module stx_shift_engine #(
  parameter int SR_W  = 24,
  parameter int LEN_W = $clog2(SR_W + 1)
) (
  input  logic             clk,
  input  logic             rst_sync_n,
  input  logic             tick,
  input  logic             fifo_valid,
  input  logic [SR_W-1:0]  image,
  input  logic [LEN_W-1:0] len,
  output logic             txd,
  output logic             empty,
  output logic             load_req
);

  logic [SR_W-1:0]  sr_q,  sr_n;
  logic [LEN_W-1:0] cnt_q, cnt_n;
  logic             txd_q, txd_n;
  logic             req_q, req_n;
  logic             busy;

  assign busy = (cnt_q != '0);

  always_comb begin
    sr_n  = sr_q;
    cnt_n = cnt_q;
    txd_n = txd_q;
    req_n = 1'b0;
    if (tick) begin
      if (busy) begin
        txd_n = sr_q[0];
        sr_n  = sr_q >> 1;
        cnt_n = cnt_q - LEN_W'(1);
        req_n = (cnt_q == LEN_W'(1));
      end else if (fifo_valid) begin
        txd_n = image[0];
        sr_n  = image >> 1;
        cnt_n = len - LEN_W'(1);
      end else begin
        txd_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
      txd_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      sr_q  <= sr_n;
      cnt_q <= cnt_n;
      txd_q <= txd_n;
      req_q <= req_n;
    end
  end

  assign txd      = txd_q;
  assign empty    = ~busy;
  assign load_req = req_q;

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load_req |=> !load_req) else $error("request longer than one cycle"); // R10
  AST_REQ_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load_req |-> empty) else $error("request while busy"); // R10
  AST_TXD_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tick |=> $stable(txd)) else $error("txd moved without a tick"); // R7
  AST_UNDERRUN_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tick && empty && !fifo_valid) |=> !txd) else $error("underrun not zero"); // R11
  AST_LOAD_FILLS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tick && empty && fifo_valid) |=> !empty) else $error("load did not fill"); // R9

endmodule

// File: rtl/serial_tx_shifter.sv
module serial_tx_shifter #(
  parameter int FIFO_W  = stx_pkg::STX_FIFO_W,
  parameter int SR_W    = stx_pkg::STX_SR_W,
  parameter int SPLIT_W = stx_pkg::STX_SPLIT_W,
  parameter int CODE_W  = stx_pkg::STX_CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_en,
  input  logic              frame_sync,
  input  logic              gated_mode,
  input  logic [CODE_W-1:0] wl_sel,
  input  logic              align_low,
  input  logic              lsb_first,
  input  logic [FIFO_W-1:0] fifo_word,
  input  logic              fifo_valid,
  output logic              txd,
  output logic              tx_empty,
  output logic              load_req
);

  localparam int LEN_W = $clog2(SR_W + 1);

  logic             rst_sync_n;
  logic             tick;
  logic [LEN_W-1:0] len;
  logic [SR_W-1:0]  sample;
  logic [SR_W-1:0]  image;

  stx_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    tick = bclk_en & (gated_mode | frame_sync);
  end

  always_comb begin
    len = LEN_W'(stx_pkg::len_of(int'(wl_sel)));
  end

  stx_word_align #(
    .FIFO_W  (FIFO_W),
    .SR_W    (SR_W),
    .SPLIT_W (SPLIT_W),
    .LEN_W   (LEN_W)
  ) u_align (
    .word      (fifo_word),
    .len       (len),
    .align_low (align_low),
    .sample    (sample)
  );

  stx_bit_order #(
    .SR_W  (SR_W),
    .LEN_W (LEN_W)
  ) u_order (
    .sample    (sample),
    .len       (len),
    .lsb_first (lsb_first),
    .image     (image)
  );

  stx_shift_engine #(
    .SR_W  (SR_W),
    .LEN_W (LEN_W)
  ) u_engine (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .tick       (tick),
    .fifo_valid (fifo_valid),
    .image      (image),
    .len        (len),
    .txd        (txd),
    .empty      (tx_empty),
    .load_req   (load_req)
  );

  AST_FS_LOW_FREEZES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!gated_mode && !frame_sync) |=> $stable(txd)) else $error("shift without frame sync"); // R7
  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_empty && !load_req) |=> !load_req) else $error("request without a finished sample"); // R10

endmodule

// File: tb/serial_tx_shifter_bench.sv
`timescale 1ns/1ps
module serial_tx_shifter_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bclk_en;
  logic        frame_sync;
  logic        gated_mode;
  logic [3:0]  wl_sel;
  logic        align_low;
  logic        lsb_first;
  logic [31:0] fifo_word;
  logic        fifo_valid;
  logic        txd;
  logic        tx_empty;
  logic        load_req;

  always #5 clk = ~clk;

  serial_tx_shifter u_serial_tx_shifter (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk_en    (bclk_en),
    .frame_sync (frame_sync),
    .gated_mode (gated_mode),
    .wl_sel     (wl_sel),
    .align_low  (align_low),
    .lsb_first  (lsb_first),
    .fifo_word  (fifo_word),
    .fifo_valid (fifo_valid),
    .txd        (txd),
    .tx_empty   (tx_empty),
    .load_req   (load_req)
  );

  int         n_tests = 0;
  int         n_fail  = 0;
  logic [1:0] exp_q[$];   // {last, bit}
  string      cur_req = "R9";
  bit         mon_on  = 1'b0;
  int         div     = 3;
  int         cyc     = 0;
  bit         done    = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int len_for(input int code);
    case (code)
      0: return 8;   1: return 10;  2: return 12;  3: return 16;
      4: return 18;  5: return 20;  6: return 22;  7: return 24;
      default: return 24;
    endcase
  endfunction

  // Strobe and frame-sync pattern generator
  always @(negedge clk) begin
    cyc++;
    bclk_en    <= ((cyc % div) == 0);
    frame_sync <= gated_mode ? 1'b0 : (((cyc / 5) % 3) != 0);
  end

  // Monitor: compares every shift opportunity against the scoreboard
  logic tk_m, prev_m, last_m;
  logic [1:0] e_m;
  initial last_m = 1'b0;
  always @(posedge clk) begin
    tk_m   = bclk_en && (gated_mode || frame_sync);
    prev_m = txd;
    #1;
    if (mon_on) begin
      if (last_m) begin
        if (!tk_m) chk(load_req == 1'b0, "R10", "load_req width", load_req, 0);
        last_m = 1'b0;
      end
      if (tk_m) begin
        if (exp_q.size() == 0) begin
          chk(txd == 1'b0, "R11", "underrun txd", txd, 0);
        end else begin
          e_m = exp_q.pop_front();
          chk(txd == e_m[0], cur_req, "txd bit", txd, e_m[0]);
          if (e_m[1]) begin
            chk(load_req && tx_empty, "R10", "req/empty after last", {load_req, tx_empty}, 3);
            last_m = 1'b1;
          end else begin
            chk(!load_req && !tx_empty, "R9", "busy req/empty", {load_req, tx_empty}, 0);
          end
        end
      end else begin
        chk(txd == prev_m, "R7", "txd hold off-tick", txd, prev_m);
      end
    end
  end

  // Driver: offers a word and pushes its expected bits
  task automatic send(input logic [31:0] w, input int code, input bit al,
                      input bit lsb, input bit scramble, input string req);
    int L, lo;
    @(negedge clk);
    L  = len_for(code);
    lo = al ? 0 : ((L >= 16) ? 24 - L : 16 - L);
    for (int k = 0; k < L; k++) begin
      int idx;
      idx = lsb ? lo + k : lo + L - 1 - k;
      exp_q.push_back({(k == L - 1), w[idx]});
    end
    cur_req    = req;
    wl_sel     = 4'(code);
    align_low  = al;
    lsb_first  = lsb;
    fifo_word  = w;
    fifo_valid = 1'b1;
    while (tx_empty) @(negedge clk);
    fifo_valid = 1'b0;
    if (scramble) begin   // R12: format inputs change mid-sample
      wl_sel    = ~4'(code);
      align_low = ~al;
      lsb_first = ~lsb;
      fifo_word = ~w;
    end
    while (!tx_empty) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; gated_mode = 1'b0; wl_sel = '0; align_low = 1'b0;
    lsb_first = 1'b0; fifo_word = '0; fifo_valid = 1'b0;
    bclk_en = 1'b0; frame_sync = 1'b0;
    repeat (4) @(negedge clk);
    chk(txd == 1'b0, "R1", "txd in reset", txd, 0);
    chk(tx_empty == 1'b1, "R1", "empty in reset", tx_empty, 1);
    chk(load_req == 1'b0, "R1", "req in reset", load_req, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(txd == 1'b0 && tx_empty && !load_req, "R1", "state after release",
        {txd, tx_empty, load_req}, 2);
    mon_on = 1'b1;

    // Continuous mode, strobe every third cycle
    send(32'hAB12_34CD, 3, 1'b0, 1'b0, 1'b0, "R4");
    send(32'h5A9C_3E71, 7, 1'b0, 1'b0, 1'b0, "R4");
    send(32'hFF12_3457, 4, 1'b0, 1'b1, 1'b0, "R6");
    send(32'h00FF_A55A, 0, 1'b0, 1'b0, 1'b0, "R5");
    send(32'hC3C3_9E81, 2, 1'b0, 1'b1, 1'b0, "R5");
    send(32'hFFFF_FE2D, 1, 1'b1, 1'b0, 1'b0, "R3");
    send(32'h8A5F_0F93, 6, 1'b1, 1'b1, 1'b0, "R3");
    send(32'h1234_5679, 12, 1'b0, 1'b0, 1'b0, "R2");
    send(32'h00F0_F0F3, 5, 1'b0, 1'b1, 1'b0, "R2");
    send(32'h7E6D_5C4B, 3, 1'b1, 1'b0, 1'b1, "R12");
    send(32'h0000_00FF, 0, 1'b1, 1'b1, 1'b0, "R6");
    repeat (40) @(negedge clk);   // R11 underrun after a sample ending in 1

    // Gated mode, frame sync held low
    gated_mode = 1'b1; div = 2;
    repeat (4) @(negedge clk);
    send(32'hDEAD_BEEF, 7, 1'b0, 1'b0, 1'b0, "R8");
    send(32'h3141_5927, 0, 1'b1, 1'b1, 1'b0, "R8");
    send(32'h2718_2818, 9, 1'b0, 1'b1, 1'b1, "R12");
    repeat (20) @(negedge clk);

    // Gated mode with a strobe every cycle
    div = 1;
    repeat (4) @(negedge clk);
    send(32'hA5A5_A5A5, 2, 1'b0, 1'b0, 1'b0, "R8");
    send(32'h0F1E_2D3C, 4, 1'b1, 1'b0, 1'b0, "R9");
    repeat (10) @(negedge clk);

    chk(exp_q.size() == 0, "R2", "all bits sent", exp_q.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R9 watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule